// File: doc/BRIEF.md
# Reference-Counted Isolation Clamp Sequencer

This block owns the isolation and core-supply controls of a pad power domain that several PHY clients share. It drives three control levels: core-voltage-down, early clamp and full clamp. It also keeps a count of the clients that currently hold the domain. Only the first enable releases the domain, and only the last disable shuts it again. Every other accepted request just moves the count. Each step of a sequence is followed by a settle interval of `SETTLE_US` microseconds, and `CYC_PER_US` converts that interval into clock cycles. A simulation can lower `CYC_PER_US` to make the interval short.

A client raises `en_req` or `dis_req` for one cycle and gives its `client_id`. Two client IDs are valid: `ID_PHY0` (default 1) and `ID_PHY1` (default 2). Rejected requests raise `err` for one cycle. Requests that are completed raise `done` for one cycle.

The controller has seven states:
- `ST_IDLE` accepts requests.
- Power-up runs `ST_UP_REL_EARLY`, then `ST_UP_REL_VDOWN`, then `ST_UP_FINISH`.
- Power-down runs `ST_DN_SET_EARLY`, then `ST_DN_SET_CLAMP`, then `ST_DN_FINISH`.

Transitions:
- A request that needs the power-up sequence moves `ST_IDLE` to `ST_UP_REL_EARLY`.
- A request that needs the power-down sequence moves `ST_IDLE` to `ST_DN_SET_EARLY`.
- Every busy state waits for the settle tick and then moves to the next state.
- `ST_UP_FINISH` and `ST_DN_FINISH` return to `ST_IDLE` on the tick.

Top module: `clamp_seq_ctrl`

## Requirements
- R1: After reset, `active_cnt` is 0, and `vcore_down`, `clamp_early` and `clamp_full` are all 1. `busy`, `done` and `err` are 0.
- R2: An enable at count 0 from a valid client starts power-up. `clamp_full` drops at the accepting edge, then `clamp_early` drops, then `vcore_down` drops. When the sequence ends, the count becomes 1.
- R3: A disable at count 1 from a valid client starts power-down. `vcore_down` rises at the accepting edge, then `clamp_early` rises, then `clamp_full` rises. When the sequence ends, the count becomes 0.
- R4: Successive steps are exactly `CYC_PER_US*SETTLE_US` cycles apart. `done` follows the last step by the same interval. `busy` is high from the accepting edge until `done`.
- R5: An enable at a nonzero count below the maximum increments the count and pulses `done` in the next cycle. The control bits do not change and `busy` stays low.
- R6: A disable at a count of 2 or more decrements the count and pulses `done` in the next cycle. The control bits do not change.
- R7: A request whose `client_id` is neither `ID_PHY0` nor `ID_PHY1` pulses `err` in the next cycle. The count and the control bits are left unchanged. With the defaults, IDs 0 and 3 are rejected.
- R8: A disable at count 0 pulses `err` and has no other effect.
- R9: While `busy` is high, requests are ignored. They produce no `err` and no `done`, and the count does not change.
- R10: `en_req` and `dis_req` raised together are rejected with `err` and have no other effect.
- R11: An enable at the maximum count (all ones in `CNT_W` bits) is rejected with `err`, and the count does not wrap.
- R12: `done` and `err` are single-cycle pulses. They are never high together, and never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_req | input | 1 | Enable request from a client (one cycle) |
| dis_req | input | 1 | Disable request from a client (one cycle) |
| client_id | input | ID_W | Identity of the requesting client |
| vcore_down | output | 1 | Core-voltage-down control, 1 = powered down |
| clamp_early | output | 1 | Early isolation clamp, 1 = clamped |
| clamp_full | output | 1 | Full isolation clamp, 1 = clamped |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is rejected |
| active_cnt | output | CNT_W | Number of clients currently holding the domain |

## Verification
The hardest situation to reach is a request that arrives in the middle of a sequence. A busy window lasts only three settle intervals, and the bench must land a request inside it and then confirm that the request left no trace. To do this, the request task can inject a random enable, disable, or bad-ID request at a chosen cycle inside a running sequence. The task keeps checking every cycle that the step timing, the count and the pulse outputs are undisturbed. The saturated-count rejection is also hard to reach, because it needs a climb to the maximum count. The bench uses a narrow count width, and directed steps climb to the top before the random phase.

// File: rtl/clamp_seq_pkg.sv
package clamp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_UP_REL_EARLY = 3'd1,
        ST_UP_REL_VDOWN = 3'd2,
        ST_UP_FINISH    = 3'd3,
        ST_DN_SET_EARLY = 3'd4,
        ST_DN_SET_CLAMP = 3'd5,
        ST_DN_FINISH    = 3'd6
    } seq_state_t;

    typedef enum logic [2:0] {
        RQ_NONE     = 3'd0,
        RQ_REJECT   = 3'd1,
        RQ_COUNT_UP = 3'd2,
        RQ_COUNT_DN = 3'd3,
        RQ_SEQ_UP   = 3'd4,
        RQ_SEQ_DN   = 3'd5
    } req_kind_t;

    typedef struct packed {
        logic vcore_down;
        logic clamp_early;
        logic clamp_full;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{vcore_down: 1'b1, clamp_early: 1'b1, clamp_full: 1'b1};

endpackage

// File: rtl/clamp_req_decode.sv
module clamp_req_decode
    import clamp_seq_pkg::*;
#(
    parameter int ID_W    = 2,
    parameter int ID_PHY0 = 1,
    parameter int ID_PHY1 = 2
) (
    input  logic            en_req,
    input  logic            dis_req,
    input  logic [ID_W-1:0] client_id,
    input  logic            cnt_zero,
    input  logic            cnt_one,
    input  logic            cnt_full,
    output req_kind_t       kind
);
    logic id_ok;

    assign id_ok = (client_id == ID_W'(ID_PHY0)) || (client_id == ID_W'(ID_PHY1));

    always_comb begin
        kind = RQ_NONE;
        if (en_req && dis_req) begin
            kind = RQ_REJECT;
        end else if (en_req || dis_req) begin
            if (!id_ok) begin
                kind = RQ_REJECT;
            end else if (en_req) begin
                if (cnt_full)      kind = RQ_REJECT;
                else if (cnt_zero) kind = RQ_SEQ_UP;
                else               kind = RQ_COUNT_UP;
            end else begin
                if (cnt_zero)      kind = RQ_REJECT;
                else if (cnt_one)  kind = RQ_SEQ_DN;
                else               kind = RQ_COUNT_DN;
            end
        end
    end
endmodule

// File: rtl/clamp_settle_timer.sv
module clamp_settle_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    generate
        if (LIMIT <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_cnt
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (run) begin
                    if (cnt == CW'(LIMIT - 1)) cnt <= '0;
                    else                       cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == CW'(LIMIT - 1));
        end
    endgenerate
endmodule

// File: rtl/clamp_refcount.sv
module clamp_refcount #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero,
    output logic             is_one,
    output logic             is_full
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
        else if (dec) cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == CNT_W'(1));
    assign is_full = (cnt == CNT_MAX);

    p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        inc |-> !is_full);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        dec |-> !is_zero);
    p_inc_dec_excl_r12: assert property (@(posedge clk) disable iff (rst)
        inc |-> !dec);
endmodule

// File: rtl/clamp_seq_ctrl.sv
module clamp_seq_ctrl
    import clamp_seq_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int SETTLE_US  = 100,
    parameter int CNT_W      = 3,
    parameter int ID_W       = 2,
    parameter int ID_PHY0    = 1,
    parameter int ID_PHY1    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic [ID_W-1:0]  client_id,
    output logic             vcore_down,
    output logic             clamp_early,
    output logic             clamp_full,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [CNT_W-1:0] active_cnt
);
    localparam int STEP_CYC = CYC_PER_US * SETTLE_US;

    seq_state_t state, state_nxt;
    req_kind_t  kind;
    ctrl_t      ctrl_q;
    logic       tick, done_q, err_q;
    logic       cnt_inc, cnt_dec, c_zero, c_one, c_full;
    logic       en_g, dis_g, last_step;

    assign busy  = (state != ST_IDLE);
    assign en_g  = en_req  && !busy;
    assign dis_g = dis_req && !busy;

    clamp_req_decode #(.ID_W(ID_W), .ID_PHY0(ID_PHY0), .ID_PHY1(ID_PHY1)) u_dec (
        .en_req(en_g), .dis_req(dis_g), .client_id(client_id),
        .cnt_zero(c_zero), .cnt_one(c_one), .cnt_full(c_full), .kind(kind)
    );

    clamp_settle_timer #(.LIMIT(STEP_CYC)) u_tmr (
        .clk(clk), .rst(rst), .run(busy), .tick(tick)
    );

    assign last_step = tick && ((state == ST_UP_FINISH) || (state == ST_DN_FINISH));
    assign cnt_inc   = (kind == RQ_COUNT_UP) || (tick && state == ST_UP_FINISH);
    assign cnt_dec   = (kind == RQ_COUNT_DN) || (tick && state == ST_DN_FINISH);

    clamp_refcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(cnt_inc), .dec(cnt_dec),
        .cnt(active_cnt), .is_zero(c_zero), .is_one(c_one), .is_full(c_full)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (kind == RQ_SEQ_UP)      state_nxt = ST_UP_REL_EARLY;
                else if (kind == RQ_SEQ_DN) state_nxt = ST_DN_SET_EARLY;
            end
            ST_UP_REL_EARLY: if (tick) state_nxt = ST_UP_REL_VDOWN;
            ST_UP_REL_VDOWN: if (tick) state_nxt = ST_UP_FINISH;
            ST_UP_FINISH:    if (tick) state_nxt = ST_IDLE;
            ST_DN_SET_EARLY: if (tick) state_nxt = ST_DN_SET_CLAMP;
            ST_DN_SET_CLAMP: if (tick) state_nxt = ST_DN_FINISH;
            ST_DN_FINISH:    if (tick) state_nxt = ST_IDLE;
            default:                   state_nxt = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (kind == RQ_COUNT_UP) || (kind == RQ_COUNT_DN) || last_step;
            err_q  <= (kind == RQ_REJECT);
            unique case (state)
                ST_IDLE: begin
                    if (kind == RQ_SEQ_UP)      ctrl_q.clamp_full <= 1'b0;
                    else if (kind == RQ_SEQ_DN) ctrl_q.vcore_down <= 1'b1;
                end
                ST_UP_REL_EARLY: if (tick) ctrl_q.clamp_early <= 1'b0;
                ST_UP_REL_VDOWN: if (tick) ctrl_q.vcore_down  <= 1'b0;
                ST_DN_SET_EARLY: if (tick) ctrl_q.clamp_early <= 1'b1;
                ST_DN_SET_CLAMP: if (tick) ctrl_q.clamp_full  <= 1'b1;
                default: ;
            endcase
        end
    end

    assign vcore_down  = ctrl_q.vcore_down;
    assign clamp_early = ctrl_q.clamp_early;
    assign clamp_full  = ctrl_q.clamp_full;
    assign done        = done_q;
    assign err         = err_q;

    p_early_after_clamp_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(clamp_early) |-> (!clamp_full && vcore_down));
    p_vdown_last_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(vcore_down) |-> (!clamp_early && !clamp_full));
    p_early_after_vdown_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_early) |-> (vcore_down && !clamp_full));
    p_clamp_last_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_full) |-> (vcore_down && clamp_early));
    p_idle_ctrl_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> $stable(ctrl_q));
    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!done && !err && $stable(active_cnt)));
    p_pulse_excl_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !err);
endmodule

// File: tb/tb_clamp_seq_ctrl.sv
`timescale 1ns/100ps
module tb_clamp_seq_ctrl;
    localparam int CPU = 2;
    localparam int SUS = 10;
    localparam int S   = CPU * SUS;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_req = 1'b0, dis_req = 1'b0;
    logic [1:0] client_id = 2'd0;
    logic vcore_down, clamp_early, clamp_full, busy, done, err;
    logic [CW-1:0] active_cnt;
    logic [2:0] bits;

    int checks = 0, fails = 0;
    int m_cnt = 0;
    int m_bits = 7;

    always #2.5 clk = ~clk;

    clamp_seq_ctrl #(.CYC_PER_US(CPU), .SETTLE_US(SUS), .CNT_W(CW),
                     .ID_W(2), .ID_PHY0(1), .ID_PHY1(2)) dut (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
        .client_id(client_id), .vcore_down(vcore_down), .clamp_early(clamp_early),
        .clamp_full(clamp_full), .busy(busy), .done(done), .err(err),
        .active_cnt(active_cnt)
    );

    assign bits = {vcore_down, clamp_early, clamp_full};

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // 0 reject, 1 count only, 2 power-up sequence, 3 power-down sequence
    function automatic int classify(bit en, bit dis, int id, int cnt, output string tag);
        int maxc = (1 << CW) - 1;
        bit idok = (id == 1) || (id == 2);
        if (en && dis) begin tag = "R10"; return 0; end
        if (!idok)     begin tag = "R7";  return 0; end
        if (en) begin
            if (cnt == maxc) begin tag = "R11"; return 0; end
            if (cnt == 0)    begin tag = "R2";  return 2; end
            tag = "R5"; return 1;
        end
        if (cnt == 0) begin tag = "R8"; return 0; end
        if (cnt == 1) begin tag = "R3"; return 3; end
        tag = "R6"; return 1;
    endfunction

    // {vcore_down, clamp_early, clamp_full} t cycles after the accepting edge
    function automatic int exp_seq(bit up, int t);
        int steps = 1 + (t - 1) / S;
        if (steps > 3) steps = 3;
        if (up) return (steps == 1) ? 6 : (steps == 2) ? 4 : 0;
        return (steps == 1) ? 4 : (steps == 2) ? 6 : 7;
    endfunction

    task automatic do_req(bit en, bit dis, int id, int intrude);
        string tag;
        int k, nc;
        k = classify(en, dis, id, m_cnt, tag);
        @(negedge clk);
        en_req = en; dis_req = dis; client_id = 2'(id);
        @(negedge clk);
        en_req = 1'b0; dis_req = 1'b0;
        if (k == 0) begin
            chk(tag, "err", err, 1);
            chk(tag, "done", done, 0);
            chk(tag, "busy", busy, 0);
            chk(tag, "count", active_cnt, m_cnt);
            chk(tag, "ctrl", bits, m_bits);
        end else if (k == 1) begin
            nc = en ? m_cnt + 1 : m_cnt - 1;
            chk(tag, "done", done, 1);
            chk(tag, "err", err, 0);
            chk(tag, "busy", busy, 0);
            chk(tag, "count", active_cnt, nc);
            chk(tag, "ctrl", bits, m_bits);
            m_cnt = nc;
        end else begin
            for (int t = 1; t <= 3 * S; t++) begin
                if (t > 1) @(negedge clk);
                chk("R4", "ctrl step", bits, exp_seq(k == 2, t));
                chk(tag, "busy", busy, 1);
                chk("R9", "done in busy", done, 0);
                chk("R9", "err in busy", err, 0);
                chk("R9", "count in busy", active_cnt, m_cnt);
                if (t == intrude) begin
                    en_req = 1'($urandom % 2); dis_req = 1'($urandom % 2);
                    client_id = 2'($urandom % 4);
                end else begin
                    en_req = 1'b0; dis_req = 1'b0;
                end
            end
            @(negedge clk);
            en_req = 1'b0; dis_req = 1'b0;
            m_cnt  = (k == 2) ? 1 : 0;
            m_bits = (k == 2) ? 0 : 7;
            chk("R4", "done at end", done, 1);
            chk(tag, "busy end", busy, 0);
            chk(tag, "count end", active_cnt, m_cnt);
            chk(tag, "ctrl end", bits, m_bits);
        end
        @(negedge clk);
        chk("R12", "done drop", done, 0);
        chk("R12", "err drop", err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1", "ctrl", bits, 7);
        chk("R1", "count", active_cnt, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);

        do_req(0, 1, 1, 0);   // R8
        do_req(1, 0, 0, 0);   // R7
        do_req(1, 0, 3, 0);   // R7
        do_req(1, 1, 1, 0);   // R10
        do_req(1, 0, 1, 0);   // R2
        do_req(1, 0, 2, 0);   // R5
        do_req(1, 0, 1, 0);   // R5 -> 3
        do_req(1, 0, 2, 0);   // R11
        do_req(0, 1, 1, 0);   // R6
        do_req(0, 1, 2, 0);   // R6
        do_req(0, 1, 0, 0);   // R7 at count 1
        do_req(0, 1, 1, 0);   // R3
        do_req(1, 0, 2, S / 2);      // R9 intrusion on power-up
        do_req(0, 1, 2, 2 * S + 1);  // R9 intrusion on power-down

        for (int i = 0; i < 250; i++) begin
            int r, id, intr;
            bit en, dis;
            r   = $urandom % 100;
            en  = (r < 50) || (r >= 95);
            dis = (r >= 50);
            id  = ($urandom % 100 < 85) ? 1 + ($urandom % 2) : (($urandom % 2) ? 0 : 3);
            intr = ($urandom % 3 == 0) ? 1 + ($urandom % (3 * S - 1)) : 0;
            do_req(en, dis, id, intr);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule